// File: doc/BRIEF.md
# Fast Page Mode DRAM Access Controller

This block turns single-start processor bus transfers into strobe sequences for an asynchronous DRAM with two banks. The first access to a row strobes the row address with the bank's row strobe, and then the column address with the column strobe. The row strobe stays low after the transfer ends, so a later access that falls in the same page needs only a column cycle. A page miss, a switch to the other bank, a lost bus grant or a pending refresh releases the row strobe. The next row strobe on either bank waits out a programmable precharge interval.

When the operand is wider than the configured DRAM port, one transfer start yields a burst of 2, 4, 8 or 16 segments. Each segment moves on its own column strobe, and the bus side sees one acknowledge pulse per segment. Read and write bursts produce the same strobe sequence. The data path is outside this block. All timing is counted in whole clock cycles. The fastest setting gives 3 clocks for an initial access from a closed page and 2 clocks per further segment.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: While rst_n is low, ras_n is 2'b11, cas_n is 1 and seg_ack is 0.
- R2: Starting from a closed page whose precharge has elapsed, a transfer first drives one row cycle, then one column setup cycle, then one cycle with cas_n low and seg_ack high. The first seg_ack is therefore in the 3rd cycle after the edge that samples xfer_start.
- R3: A page hit leaves ras_n unchanged, skips the row cycle, and gives the first seg_ack in the 2nd cycle after the start edge. cas_n is never low while both ras_n bits are high.
- R4: cfg_page_size selects the bits compared for a hit against the address stored when the page was opened. Code 0 compares bits 31..9, code 1 compares bits 31..10, and codes 2 and 3 compare bits 31..11.
- R5: On a page miss to an open page, ras_n goes to 2'b11 for cfg_rp_clks cycles before the next row cycle. The first seg_ack is therefore in cycle cfg_rp_clks+3 after the start edge.
- R6: Address bit 24 selects the bank: 0 drives ras_n[0] low and 1 drives ras_n[1] low. At most one bank's ras_n is low at any time. An access to the other bank is a miss that closes the open page and precharges it (R5).
- R7: If bus_lost or refresh_pend is high in a cycle with no transfer running, an open page is closed at that edge. The next transfer is a miss, and its row cycle waits until the precharge has elapsed.
- R8: xfer_size codes 0, 1, 2 and 3 mean 1, 2, 4 and 16 bytes. cfg_port_size codes 0, 1, 2 and 3 mean 1, 2, 4 and 4 bytes. The number of seg_ack pulses is max(1, operand bytes / port bytes), and successive pulses are exactly 2 cycles apart.
- R9: During each seg_ack cycle, dram_addr carries the column of that segment. The column is (xfer_addr + i * port bytes) masked to the bits below the page-size boundary of R4, where i counts segments from 0.
- R10: A transfer start that arrives in the same cycle as bus_lost or refresh_pend is treated as a miss even when its address would hit. The page is closed and precharged (R5 latency).
- R11: A cfg_rp_clks value of 0 is treated as 1 precharge cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_start | input | 1 | One-cycle transfer start, taken only when no transfer is running |
| xfer_addr | input | 32 | Byte address of the transfer |
| xfer_size | input | 2 | Operand size code (R8) |
| bus_lost | input | 1 | Processor has lost the bus grant |
| refresh_pend | input | 1 | A refresh is waiting |
| cfg_page_size | input | 2 | Page size code (R4) |
| cfg_port_size | input | 2 | DRAM port width code (R8) |
| cfg_rp_clks | input | 4 | Row precharge length in clocks |
| seg_ack | output | 1 | One pulse per segment moved |
| ras_n | output | 2 | Active-low row strobe, one per bank |
| cas_n | output | 1 | Active-low column strobe |
| dram_addr | output | 12 | Multiplexed row/column address |

## Verification
A transfer start and a page-closing event can land in the same clock. The case that matters is a start whose address matches the open page while refresh_pend or bus_lost is also high. The bench drives both in one cycle, to an address that hit the page just before. It judges the outcome by the first-acknowledge latency, which must be cfg_rp_clks+3 and not 2, and by the bank strobe that is low when the acknowledge arrives. A second overlap, a lost grant that comes with a 16-segment burst start, is judged the same way, together with the acknowledge count and the column of every segment.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  localparam int unsigned PAGE_LO_MIN = 9;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_ROW, ST_COL, ST_CAS, ST_CASP
  } fpm_state_e;

  function automatic int unsigned page_lo(input logic [1:0] ps);
    return PAGE_LO_MIN + ((ps == 2'd3) ? 2 : int'(ps));
  endfunction
endpackage

// File: rtl/fpm_burst_calc.sv
module fpm_burst_calc #(
  parameter int SEG_W = 4
) (
  input  logic [1:0]       size_code,
  input  logic [1:0]       port_code,
  output logic [SEG_W-1:0] seg_m1,
  output logic [1:0]       step_log
);
  logic [2:0] op_log;
  logic [2:0] pt_log;
  logic [2:0] n_log;

  always_comb begin
    op_log = (size_code == 2'd3) ? 3'd4 : {1'b0, size_code};
    pt_log = (port_code == 2'd3) ? 3'd2 : {1'b0, port_code};
    n_log  = (op_log > pt_log) ? op_log - pt_log : 3'd0;
    seg_m1 = SEG_W'((32'd1 << n_log) - 32'd1);
    step_log = pt_log[1:0];
  end
endmodule

// File: rtl/fpm_page_track.sv
module fpm_page_track #(
  parameter int ADDR_W   = 32,
  parameter int BANK_BIT = 24,
  parameter int NBANK    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_page_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              open_en,
  input  logic              close_en,
  output logic              page_open,
  output logic              page_hit,
  output logic [NBANK-1:0]  ras_n
);
  import fpm_pkg::*;
  localparam int BIDX_W = (NBANK > 1) ? $clog2(NBANK) : 1;

  logic              valid_q, valid_d;
  logic [ADDR_W-1:0] row_q, row_d;
  logic [BIDX_W-1:0] bank_q;
  logic [ADDR_W-1:0] cmp_mask;

  always_comb begin
    cmp_mask = ~((ADDR_W'(1) << page_lo(cfg_page_size)) - ADDR_W'(1));
    valid_d  = valid_q;
    row_d    = row_q;
    if (close_en) valid_d = 1'b0;
    if (open_en) begin
      valid_d = 1'b1;
      row_d   = load_addr;
    end
    page_hit = valid_q && (((req_addr ^ row_q) & cmp_mask) == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      row_q   <= '0;
    end else begin
      valid_q <= valid_d;
      if (open_en) row_q <= row_d;
    end
  end

  assign bank_q    = row_q[BANK_BIT +: BIDX_W];
  assign page_open = valid_q;

  for (genvar b = 0; b < NBANK; b++) begin : g_ras
    assign ras_n[b] = !(valid_q && (bank_q == BIDX_W'(b)));
  end

  a_r6_single_bank: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~ras_n));
  a_r7_close_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (close_en && !open_en) |=> (ras_n == '1));
endmodule

// File: rtl/fpm_seq.sv
module fpm_seq #(
  parameter int ADDR_W = 32,
  parameter int SEG_W  = 4,
  parameter int RP_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_start,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              close_req,
  input  logic              page_hit,
  input  logic              page_open,
  input  logic [SEG_W-1:0]  seg_m1,
  input  logic [1:0]        step_log,
  input  logic [RP_W-1:0]   cfg_rp,
  output logic              open_en,
  output logic              close_en,
  output logic [ADDR_W-1:0] load_addr,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              row_phase,
  output logic              seg_ack,
  output logic              cas_n
);
  import fpm_pkg::*;

  fpm_state_e        state_q, state_d;
  logic [RP_W-1:0]   rp_q, rp_d, rp_eff, rp_dec;
  logic [SEG_W-1:0]  segs_q, segs_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [1:0]        step_q, step_d;

  always_comb begin
    rp_eff   = (cfg_rp == '0) ? RP_W'(1) : cfg_rp;
    rp_dec   = (rp_q != '0) ? rp_q - RP_W'(1) : '0;
    state_d  = state_q;
    rp_d     = rp_dec;
    segs_d   = segs_q;
    addr_d   = addr_q;
    step_d   = step_q;
    open_en  = 1'b0;
    close_en = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (xfer_start) begin
          addr_d = req_addr;
          segs_d = seg_m1;
          step_d = step_log;
          if (page_hit && !close_req) begin
            state_d = ST_COL;
          end else if (page_open) begin
            close_en = 1'b1;
            rp_d     = rp_eff;
            state_d  = ST_PRE;
          end else if (rp_q > RP_W'(1)) begin
            state_d = ST_PRE;
          end else begin
            open_en = 1'b1;
            state_d = ST_ROW;
          end
        end else if (close_req && page_open) begin
          close_en = 1'b1;
          rp_d     = rp_eff;
        end
      end
      ST_PRE: begin
        if (rp_q <= RP_W'(1)) begin
          open_en = 1'b1;
          state_d = ST_ROW;
        end
      end
      ST_ROW:  state_d = ST_COL;
      ST_COL:  state_d = ST_CAS;
      ST_CAS: begin
        if (segs_q == '0) begin
          state_d = ST_IDLE;
        end else begin
          segs_d  = segs_q - SEG_W'(1);
          addr_d  = addr_q + (ADDR_W'(1) << step_q);
          state_d = ST_CASP;
        end
      end
      ST_CASP: state_d = ST_CAS;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rp_q    <= '0;
      segs_q  <= '0;
      addr_q  <= '0;
      step_q  <= '0;
    end else begin
      state_q <= state_d;
      rp_q    <= rp_d;
      segs_q  <= segs_d;
      addr_q  <= addr_d;
      step_q  <= step_d;
    end
  end

  assign load_addr = (state_q == ST_IDLE) ? req_addr : addr_q;
  assign cur_addr  = addr_q;
  assign row_phase = (state_q == ST_ROW);
  assign seg_ack   = (state_q == ST_CAS);
  assign cas_n     = !(state_q == ST_CAS);

  a_r8_ack_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    seg_ack |=> !seg_ack);
  a_r5_row_after_precharge: assert property (@(posedge clk) disable iff (!rst_n)
    row_phase |-> (rp_q == '0));
endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl #(
  parameter int ADDR_W   = 32,
  parameter int DADDR_W  = 12,
  parameter int BANK_BIT = 24,
  parameter int NBANK    = 2,
  parameter int SEG_W    = 4,
  parameter int RP_W     = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               xfer_start,
  input  logic [ADDR_W-1:0]  xfer_addr,
  input  logic [1:0]         xfer_size,
  input  logic               bus_lost,
  input  logic               refresh_pend,
  input  logic [1:0]         cfg_page_size,
  input  logic [1:0]         cfg_port_size,
  input  logic [RP_W-1:0]    cfg_rp_clks,
  output logic               seg_ack,
  output logic [NBANK-1:0]   ras_n,
  output logic               cas_n,
  output logic [DADDR_W-1:0] dram_addr
);
  import fpm_pkg::*;

  logic [SEG_W-1:0]  seg_m1;
  logic [1:0]        step_log;
  logic              page_open, page_hit, open_en, close_en, row_phase;
  logic [ADDR_W-1:0] load_addr, cur_addr, col_mask;
  logic              close_req;

  assign close_req = bus_lost | refresh_pend;

  fpm_burst_calc #(.SEG_W(SEG_W)) u_burst (
    .size_code (xfer_size),
    .port_code (cfg_port_size),
    .seg_m1    (seg_m1),
    .step_log  (step_log)
  );

  fpm_page_track #(.ADDR_W(ADDR_W), .BANK_BIT(BANK_BIT), .NBANK(NBANK)) u_track (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_page_size (cfg_page_size),
    .req_addr      (xfer_addr),
    .load_addr     (load_addr),
    .open_en       (open_en),
    .close_en      (close_en),
    .page_open     (page_open),
    .page_hit      (page_hit),
    .ras_n         (ras_n)
  );

  fpm_seq #(.ADDR_W(ADDR_W), .SEG_W(SEG_W), .RP_W(RP_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .xfer_start (xfer_start),
    .req_addr   (xfer_addr),
    .close_req  (close_req),
    .page_hit   (page_hit),
    .page_open  (page_open),
    .seg_m1     (seg_m1),
    .step_log   (step_log),
    .cfg_rp     (cfg_rp_clks),
    .open_en    (open_en),
    .close_en   (close_en),
    .load_addr  (load_addr),
    .cur_addr   (cur_addr),
    .row_phase  (row_phase),
    .seg_ack    (seg_ack),
    .cas_n      (cas_n)
  );

  always_comb begin
    col_mask = (ADDR_W'(1) << page_lo(cfg_page_size)) - ADDR_W'(1);
    if (row_phase) dram_addr = DADDR_W'(cur_addr >> page_lo(cfg_page_size));
    else           dram_addr = DADDR_W'(cur_addr & col_mask);
  end

  // Checker: consecutive cycles with every row strobe released.
  logic [RP_W-1:0] hi_q;
  logic [RP_W-1:0] rp_min;
  assign rp_min = (cfg_rp_clks == '0) ? RP_W'(1) : cfg_rp_clks;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               hi_q <= '1;
    else if (ras_n != '1)     hi_q <= '0;
    else if (hi_q != '1)      hi_q <= hi_q + RP_W'(1);
  end

  a_r3_cas_needs_ras: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> (ras_n != '1));
  a_r5_precharge_time: assert property (@(posedge clk) disable iff (!rst_n)
    ((ras_n != '1) && ($past(ras_n) == '1)) |-> (hi_q >= rp_min));
  a_r8_ack_with_cas: assert property (@(posedge clk) disable iff (!rst_n)
    seg_ack |-> !cas_n);
endmodule

// File: tb/fpm_dram_ctrl_bench.sv
module fpm_dram_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        xfer_start, bus_lost, refresh_pend;
  logic [31:0] xfer_addr;
  logic [1:0]  xfer_size, cfg_page_size, cfg_port_size;
  logic [3:0]  cfg_rp_clks;
  logic        seg_ack, cas_n;
  logic [1:0]  ras_n;
  logic [11:0] dram_addr;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cycles <= cycles + 1;

  fpm_dram_ctrl u_fpm_dram_ctrl (
    .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_addr(xfer_addr),
    .xfer_size(xfer_size), .bus_lost(bus_lost), .refresh_pend(refresh_pend),
    .cfg_page_size(cfg_page_size), .cfg_port_size(cfg_port_size),
    .cfg_rp_clks(cfg_rp_clks), .seg_ack(seg_ack), .ras_n(ras_n),
    .cas_n(cas_n), .dram_addr(dram_addr)
  );

  typedef struct packed {
    logic [1:0]  ps;
    logic [1:0]  port;
    logic [1:0]  size;
    logic        refr;
    logic        lost;
    logic [31:0] addr;
    logic [7:0]  lat;
    logic [7:0]  segs;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 2'd2, 2'd2, 1'b0, 1'b0, 32'h0000_0000, 8'd3, 8'd1},  // R2 cold miss
    '{2'd0, 2'd2, 2'd2, 1'b0, 1'b0, 32'h0000_01FC, 8'd2, 8'd1},  // R3 hit
    '{2'd0, 2'd2, 2'd2, 1'b0, 1'b0, 32'h0000_0200, 8'd5, 8'd1},  // R4/R5 bit 9 miss
    '{2'd1, 2'd2, 2'd2, 1'b0, 1'b0, 32'h0000_0000, 8'd2, 8'd1},  // R4 1 KB hit
    '{2'd1, 2'd2, 2'd2, 1'b0, 1'b0, 32'h0000_0400, 8'd5, 8'd1},  // R4 bit 10 miss
    '{2'd2, 2'd2, 2'd2, 1'b0, 1'b0, 32'h0000_07FC, 8'd2, 8'd1},  // R4 2 KB hit
    '{2'd3, 2'd2, 2'd2, 1'b0, 1'b0, 32'h0000_0000, 8'd2, 8'd1},  // R4 code 3 as 2 KB
    '{2'd2, 2'd2, 2'd2, 1'b0, 1'b0, 32'h0000_0800, 8'd5, 8'd1},  // R5 bit 11 miss
    '{2'd2, 2'd2, 2'd2, 1'b0, 1'b0, 32'h0100_0800, 8'd5, 8'd1},  // R6 other bank
    '{2'd2, 2'd2, 2'd2, 1'b0, 1'b0, 32'h0000_0800, 8'd5, 8'd1},  // R6 back to bank 0
    '{2'd2, 2'd2, 2'd2, 1'b1, 1'b0, 32'h0000_0804, 8'd5, 8'd1},  // R10 refresh + start
    '{2'd2, 2'd2, 2'd3, 1'b0, 1'b0, 32'h0000_0900, 8'd2, 8'd4},  // R8 line on 32-bit
    '{2'd2, 2'd0, 2'd3, 1'b0, 1'b1, 32'h0000_0900, 8'd5, 8'd16}, // R10 lost + 16-seg burst
    '{2'd2, 2'd0, 2'd1, 1'b0, 1'b0, 32'h0000_0902, 8'd2, 8'd2},  // R8 half on 8-bit
    '{2'd2, 2'd2, 2'd0, 1'b0, 1'b0, 32'h0000_0903, 8'd2, 8'd1}   // R8 byte on 32-bit
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_xfer(input vec_t v, input string tag);
    int cnt, acks, last, first_lat, step, lo, bad_gap;
    logic [31:0] mask, col;
    logic [1:0] exp_ras;
    step = (v.port == 2'd3) ? 4 : (1 << v.port);
    lo = 9 + ((v.ps == 2'd3) ? 2 : int'(v.ps));
    mask = (32'd1 << lo) - 32'd1;
    exp_ras = v.addr[24] ? 2'b01 : 2'b10;
    cfg_page_size = v.ps; cfg_port_size = v.port; xfer_size = v.size;
    xfer_addr = v.addr; refresh_pend = v.refr; bus_lost = v.lost;
    xfer_start = 1'b1;
    acks = 0; last = 0; first_lat = 0; bad_gap = 0;
    @(negedge clk);
    xfer_start = 1'b0; refresh_pend = 1'b0; bus_lost = 1'b0;
    for (int c = 1; c <= int'(v.lat) + 2 * int'(v.segs) + 4; c++) begin
      cnt = c;
      if (seg_ack) begin
        if (acks == 0) begin
          first_lat = cnt;
          check(ras_n == exp_ras, {tag, " R6 bank strobe"}, ras_n, exp_ras);
        end else if (cnt - last != 2) begin
          bad_gap = cnt - last;
        end
        col = ((v.addr + 32'(acks * step)) & mask);
        check(dram_addr == col[11:0], {tag, " R9 column"}, dram_addr, col[11:0]);
        last = cnt;
        acks++;
      end
      @(negedge clk);
    end
    check(first_lat == int'(v.lat), {tag, " latency"}, first_lat, v.lat);
    check(acks == int'(v.segs), {tag, " R8 ack count"}, acks, v.segs);
    check(bad_gap == 0, {tag, " R8 ack gap"}, bad_gap, 2);
  endtask

  initial begin
    while (cycles < 20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", cycles, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; xfer_start = 1'b0; bus_lost = 1'b0; refresh_pend = 1'b0;
    xfer_addr = '0; xfer_size = 2'd2; cfg_page_size = 2'd0;
    cfg_port_size = 2'd2; cfg_rp_clks = 4'd2;
    repeat (3) @(negedge clk);
    check(ras_n == 2'b11, "R1 ras_n in reset", ras_n, 2'b11);
    check(cas_n == 1'b1, "R1 cas_n in reset", cas_n, 1);
    check(seg_ack == 1'b0, "R1 seg_ack in reset", seg_ack, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      run_xfer(VEC[i], $sformatf("R2 R3 R4 R5 vec%0d", i));
    end

    // R7: refresh while idle closes the open page
    check(ras_n == 2'b10, "R7 page open before refresh", ras_n, 2'b10);
    refresh_pend = 1'b1;
    @(negedge clk);
    refresh_pend = 1'b0;
    check(ras_n == 2'b11, "R7 ras released on refresh", ras_n, 2'b11);
    repeat (3) @(negedge clk);
    check(ras_n == 2'b11, "R7 page stays closed", ras_n, 2'b11);
    run_xfer('{2'd2, 2'd2, 2'd2, 1'b0, 1'b0, 32'h0000_0904, 8'd3, 8'd1}, "R7 reopen");

    // R7: lost grant while idle, then an immediate start waits for precharge
    bus_lost = 1'b1;
    @(negedge clk);
    bus_lost = 1'b0;
    run_xfer('{2'd2, 2'd2, 2'd2, 1'b0, 1'b0, 32'h0000_0904, 8'd4, 8'd1}, "R7 early start");

    // R11: zero precharge setting acts as one cycle
    cfg_rp_clks = 4'd0;
    run_xfer('{2'd2, 2'd2, 2'd2, 1'b0, 1'b0, 32'h0000_1000, 8'd4, 8'd1}, "R11 rp zero");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule